// File: doc/BRIEF.md
# Non-Restoring Division Step Unit

This block advances a 32-bit non-restoring division by one step for each accepted request. A step takes a divisor, a partial remainder and three status flags. Q tracks the sign of the partial remainder, M holds the sign of the divisor, and T carries a bit in and a bit out. The step shifts the remainder left, feeds T into the vacated bit, then adds or subtracts the divisor. From the outcome it derives the next Q and T. M passes through unchanged.

Two setup operations prepare the flags before a division. The signed form takes Q and M from the sign bits of the dividend and divisor. The unsigned form clears all three flags. A run operation hands the whole loop to an internal sequencer. The sequencer performs one step per clock for 32 clocks and chains each step's T into the next step. It shifts every produced T into a quotient register and pulses a done flag at the end. Sign correction of the final quotient is left to the user.

Requests use a valid/ready handshake and can arrive every cycle while ready is high. All results are registered.

Top module: `nrdiv_step_unit`

## Requirements
- R1: While reset is high and in the first cycle after it, resp_valid and seq_done are 0 and req_ready is 1. A reset asserted during a run abandons the run.
- R2: On a step (req_op = 0), the shifted value is {req_rem[30:0], req_t}. If req_q equals req_m, the divisor is subtracted from the shifted value; otherwise it is added. resp_rem is the 32-bit wrapped result.
- R3: The carry flag of a subtraction is 1 when the wrapped result exceeds the shifted value. The carry flag of an addition is 1 when the wrapped result is below the shifted value. The new Q is req_rem[31] xor carry when req_m is 0, and the inverse of that when req_m is 1.
- R4: After a step, resp_t is 1 exactly when the new Q equals M, and resp_m equals req_m.
- R5: Signed setup (req_op = 1) gives resp_q = req_rem[31], resp_m = req_divisor[31] and resp_t = resp_q xor resp_m, with resp_rem = req_rem.
- R6: Unsigned setup (req_op = 2) gives resp_q = resp_m = resp_t = 0, with resp_rem = req_rem.
- R7: A request is accepted on a clock edge where req_valid and req_ready are both high. Each accepted step or setup gives resp_valid for exactly the next cycle, so back-to-back requests give back-to-back responses. A cycle without an accepted request gives no response.
- R8: A run (req_op = 3) lowers req_ready from the accepting edge. It performs 32 steps starting from the request's remainder, divisor and flags, with each step's T input taken from the previous step's T output. On the 32nd edge after acceptance, seq_done and resp_valid rise for one cycle and req_ready returns. seq_quot then holds the 32 T outputs, first step in bit 31. resp_rem, resp_q, resp_m and resp_t hold the final state.
- R9: Requests presented while req_ready is low are ignored and do not change the outcome of the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request (low while running) |
| req_op | input | 2 | 0 step, 1 signed setup, 2 unsigned setup, 3 run |
| req_rem | input | 32 | Partial remainder, or dividend for setup |
| req_divisor | input | 32 | Divisor |
| req_q | input | 1 | Incoming Q flag |
| req_m | input | 1 | Incoming M flag |
| req_t | input | 1 | Incoming T flag |
| resp_valid | output | 1 | Result registers updated by a request or a finished run |
| resp_rem | output | 32 | Resulting partial remainder |
| resp_q | output | 1 | Resulting Q |
| resp_m | output | 1 | Resulting M |
| resp_t | output | 1 | Resulting T |
| seq_done | output | 1 | One-cycle pulse at the end of a run |
| seq_quot | output | 32 | Quotient bits collected by the last run |

## Verification
Steps and setups land in the response registers on the edge that accepts them. The bench therefore drives each vector before that edge and samples one time unit after it. Because the table is walked with valid held high, it also checks that responses follow back-to-back requests. For a run, completion is due on the 32nd edge after the accepting edge. The bench confirms that done is still low after edge 31 and high after edge 32, then checks the quotient and final state against an independent 32-step model. A stray request injected during the run must leave that result unchanged.

// File: rtl/nrdiv_pkg.sv
package nrdiv_pkg;
  typedef enum logic [1:0] {
    OP_STEP   = 2'd0,
    OP_INIT_S = 2'd1,
    OP_INIT_U = 2'd2,
    OP_RUN    = 2'd3
  } div_op_e;
endpackage

// File: rtl/nrdiv_core.sv
module nrdiv_core #(
  parameter int W = 32
) (
  input  logic [W-1:0] rem_in,
  input  logic [W-1:0] div_in,
  input  logic         q_in,
  input  logic         m_in,
  input  logic         t_in,
  output logic [W-1:0] rem_out,
  output logic         q_out,
  output logic         t_out
);
  logic [W-1:0] shifted;
  logic         top_bit;
  logic         do_sub;
  logic         cflag;

  always_comb begin
    top_bit = rem_in[W-1];
    shifted = {rem_in[W-2:0], t_in};
    do_sub  = (q_in == m_in);
    if (do_sub) begin
      rem_out = shifted - div_in;
      cflag   = (rem_out > shifted);
    end else begin
      rem_out = shifted + div_in;
      cflag   = (rem_out < shifted);
    end
    q_out = top_bit ^ cflag ^ m_in;
    t_out = (q_out == m_in);
  end
endmodule

// File: rtl/nrdiv_flag_init.sv
module nrdiv_flag_init (
  input  logic signed_mode,
  input  logic dividend_msb,
  input  logic divisor_msb,
  output logic q_out,
  output logic m_out,
  output logic t_out
);
  always_comb begin
    if (signed_mode) begin
      q_out = dividend_msb;
      m_out = divisor_msb;
    end else begin
      q_out = 1'b0;
      m_out = 1'b0;
    end
    t_out = q_out ^ m_out;
  end
endmodule

// File: rtl/nrdiv_seq_ctl.sv
module nrdiv_seq_ctl #(
  parameter int W = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic last
);
  localparam int CNT_W = (W > 1) ? $clog2(W) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(W - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
      if (cnt == LAST_CNT) busy <= 1'b0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
    end
  end

  assign last = busy && (cnt == LAST_CNT);
endmodule

// File: rtl/nrdiv_step_unit.sv
module nrdiv_step_unit
  import nrdiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic [1:0]   req_op,
  input  logic [W-1:0] req_rem,
  input  logic [W-1:0] req_divisor,
  input  logic         req_q,
  input  logic         req_m,
  input  logic         req_t,
  output logic         resp_valid,
  output logic [W-1:0] resp_rem,
  output logic         resp_q,
  output logic         resp_m,
  output logic         resp_t,
  output logic         seq_done,
  output logic [W-1:0] seq_quot
);
  div_op_e      op;
  logic         accept;
  logic         busy;
  logic         last;
  logic         start;

  logic [W-1:0] rem_r, div_r, quot_r;
  logic         q_r, m_r, t_r;
  logic         valid_r, done_r;

  logic [W-1:0] c_rem, c_div, n_rem;
  logic         c_q, c_m, c_t, n_q, n_t;
  logic         i_q, i_m, i_t;

  assign op        = div_op_e'(req_op);
  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign start     = accept && (op == OP_RUN);

  assign c_rem = busy ? rem_r : req_rem;
  assign c_div = busy ? div_r : req_divisor;
  assign c_q   = busy ? q_r   : req_q;
  assign c_m   = busy ? m_r   : req_m;
  assign c_t   = busy ? t_r   : req_t;

  nrdiv_core #(.W(W)) u_core (
    .rem_in  (c_rem),
    .div_in  (c_div),
    .q_in    (c_q),
    .m_in    (c_m),
    .t_in    (c_t),
    .rem_out (n_rem),
    .q_out   (n_q),
    .t_out   (n_t)
  );

  nrdiv_flag_init u_init (
    .signed_mode  (op == OP_INIT_S),
    .dividend_msb (req_rem[W-1]),
    .divisor_msb  (req_divisor[W-1]),
    .q_out        (i_q),
    .m_out        (i_m),
    .t_out        (i_t)
  );

  nrdiv_seq_ctl #(.W(W)) u_ctl (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .busy  (busy),
    .last  (last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_r   <= '0;
      div_r   <= '0;
      quot_r  <= '0;
      q_r     <= 1'b0;
      m_r     <= 1'b0;
      t_r     <= 1'b0;
      valid_r <= 1'b0;
      done_r  <= 1'b0;
    end else begin
      valid_r <= 1'b0;
      done_r  <= 1'b0;
      if (busy) begin
        rem_r  <= n_rem;
        q_r    <= n_q;
        t_r    <= n_t;
        quot_r <= {quot_r[W-2:0], n_t};
        if (last) begin
          valid_r <= 1'b1;
          done_r  <= 1'b1;
        end
      end else if (accept) begin
        case (op)
          OP_STEP: begin
            rem_r   <= n_rem;
            q_r     <= n_q;
            m_r     <= req_m;
            t_r     <= n_t;
            valid_r <= 1'b1;
          end
          OP_INIT_S, OP_INIT_U: begin
            rem_r   <= req_rem;
            q_r     <= i_q;
            m_r     <= i_m;
            t_r     <= i_t;
            valid_r <= 1'b1;
          end
          default: begin
            rem_r  <= req_rem;
            div_r  <= req_divisor;
            q_r    <= req_q;
            m_r    <= req_m;
            t_r    <= req_t;
            quot_r <= '0;
          end
        endcase
      end
    end
  end

  assign resp_valid = valid_r;
  assign resp_rem   = rem_r;
  assign resp_q     = q_r;
  assign resp_m     = m_r;
  assign resp_t     = t_r;
  assign seq_done   = done_r;
  assign seq_quot   = quot_r;
endmodule

// File: rtl/nrdiv_step_chk.sv
module nrdiv_step_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         req_valid,
  input logic         req_ready,
  input logic [1:0]   req_op,
  input logic [W-1:0] req_rem,
  input logic [W-1:0] req_divisor,
  input logic         req_m,
  input logic         resp_valid,
  input logic [W-1:0] resp_rem,
  input logic         resp_q,
  input logic         resp_m,
  input logic         resp_t,
  input logic         seq_done
);
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!resp_valid && !seq_done && req_ready));

  assert_resp_next_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_op != 2'd3) |=> resp_valid);

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (!req_valid && req_ready) |=> !resp_valid);

  assert_keep_m_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_op == 2'd0) |=>
      (resp_m == $past(req_m) && resp_t == (resp_q == resp_m)));

  assert_signed_init_R5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_op == 2'd1) |=>
      (resp_q == $past(req_rem[W-1]) && resp_m == $past(req_divisor[W-1]) &&
       resp_t == (resp_q ^ resp_m) && resp_rem == $past(req_rem)));

  assert_unsigned_init_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_op == 2'd2) |=>
      (!resp_q && !resp_m && !resp_t && resp_rem == $past(req_rem)));

  assert_run_busy_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_op == 2'd3) |=> !req_ready);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    seq_done |=> !seq_done);

  assert_done_resp_R8: assert property (@(posedge clk) disable iff (rst)
    seq_done |-> (resp_valid && req_ready));

  assert_busy_no_resp_R9: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && !$past(req_ready) && !seq_done) |-> !resp_valid);
endmodule

bind nrdiv_step_unit nrdiv_step_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_op      (req_op),
  .req_rem     (req_rem),
  .req_divisor (req_divisor),
  .req_m       (req_m),
  .resp_valid  (resp_valid),
  .resp_rem    (resp_rem),
  .resp_q      (resp_q),
  .resp_m      (resp_m),
  .resp_t      (resp_t),
  .seq_done    (seq_done)
);

// File: tb/tb_nrdiv_step_unit.sv
module tb_nrdiv_step_unit;
  localparam int W = 32;
  localparam time CLK_PERIOD = 10;
  localparam int NVEC = 11;

  // {op, rem, divisor, q, m, t, exp_rem, exp_q, exp_m, exp_t}
  localparam logic [103:0] VEC [NVEC] = '{
    {2'd0, 32'h00000010, 32'h00000003, 1'b0, 1'b0, 1'b1, 32'h0000001E, 1'b0, 1'b0, 1'b1},
    {2'd0, 32'h00000001, 32'h00000005, 1'b0, 1'b0, 1'b0, 32'hFFFFFFFD, 1'b1, 1'b0, 1'b0},
    {2'd0, 32'h80000000, 32'h00000001, 1'b0, 1'b0, 1'b0, 32'hFFFFFFFF, 1'b0, 1'b0, 1'b1},
    {2'd0, 32'hFFFFFFFE, 32'h00000003, 1'b1, 1'b0, 1'b1, 32'h00000000, 1'b0, 1'b0, 1'b1},
    {2'd0, 32'h00000004, 32'hFFFFFFFD, 1'b0, 1'b1, 1'b0, 32'h00000005, 1'b0, 1'b1, 1'b0},
    {2'd0, 32'h40000000, 32'hFFFFFFFF, 1'b1, 1'b1, 1'b1, 32'h80000002, 1'b0, 1'b1, 1'b0},
    {2'd0, 32'h7FFFFFFF, 32'h00000001, 1'b1, 1'b1, 1'b0, 32'hFFFFFFFD, 1'b1, 1'b1, 1'b1},
    {2'd1, 32'h80000005, 32'h00000007, 1'b0, 1'b0, 1'b0, 32'h80000005, 1'b1, 1'b0, 1'b1},
    {2'd1, 32'h80000000, 32'h90000000, 1'b0, 1'b0, 1'b0, 32'h80000000, 1'b1, 1'b1, 1'b0},
    {2'd2, 32'h12345678, 32'hFFFFFFFF, 1'b1, 1'b1, 1'b1, 32'h12345678, 1'b0, 1'b0, 1'b0},
    {2'd0, 32'hC0000000, 32'h40000000, 1'b0, 1'b1, 1'b1, 32'hC0000001, 1'b0, 1'b1, 1'b0}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [1:0]   req_op = 2'd0;
  logic [W-1:0] req_rem = '0;
  logic [W-1:0] req_divisor = '0;
  logic         req_q = 1'b0, req_m = 1'b0, req_t = 1'b0;
  logic         resp_valid;
  logic [W-1:0] resp_rem;
  logic         resp_q, resp_m, resp_t;
  logic         seq_done;
  logic [W-1:0] seq_quot;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  nrdiv_step_unit #(.W(W)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_rem(req_rem), .req_divisor(req_divisor),
    .req_q(req_q), .req_m(req_m), .req_t(req_t),
    .resp_valid(resp_valid), .resp_rem(resp_rem), .resp_q(resp_q),
    .resp_m(resp_m), .resp_t(resp_t), .seq_done(seq_done), .seq_quot(seq_quot)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Independent model of one step: returns {rem, q, t}
  function automatic logic [W+1:0] model_step(input logic [W-1:0] r, input logic [W-1:0] d,
                                               input logic q, input logic m, input logic t);
    logic [W-1:0] sh;
    logic [W:0]   wide;
    logic         c, nq;
    sh = {r[W-2:0], t};
    if (q == m) wide = {1'b0, sh} - {1'b0, d};
    else        wide = {1'b0, sh} + {1'b0, d};
    c = wide[W];
    if (m == 1'b0) nq = r[W-1] ^ c;
    else           nq = ~(r[W-1] ^ c);
    return {wide[W-1:0], nq, (nq == m)};
  endfunction

  task automatic run_case(input logic [W-1:0] r0, input logic [W-1:0] d,
                          input logic q0, input logic m0, input logic t0, input bit inject);
    logic [W-1:0] er, eq_quot;
    logic         eq, et;
    logic [W+1:0] s;
    er = r0; eq = q0; et = t0; eq_quot = '0;
    for (int k = 0; k < W; k++) begin
      s = model_step(er, d, eq, m0, et);
      er = s[W+1:2]; eq = s[1]; et = s[0];
      eq_quot = {eq_quot[W-2:0], et};
    end
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd3; req_rem = r0; req_divisor = d;
    req_q = q0; req_m = m0; req_t = t0;
    @(posedge clk); #1;
    chk("R8 ready low after run accepted", {63'd0, req_ready}, 64'd0);
    @(negedge clk);
    if (inject) begin
      req_op = 2'd0; req_rem = 32'hDEADBEEF; req_divisor = 32'h00000001;
      req_q = ~q0; req_m = ~m0; req_t = ~t0;
    end else begin
      req_valid = 1'b0;
    end
    repeat (31) @(posedge clk);
    #1;
    chk("R8 done not before edge 32", {63'd0, seq_done}, 64'd0);
    chk("R9 no response while busy", {63'd0, resp_valid}, 64'd0);
    @(posedge clk); #1;
    chk("R8 done on edge 32", {63'd0, seq_done}, 64'd1);
    chk("R8 resp_valid with done", {63'd0, resp_valid}, 64'd1);
    chk("R8 ready back", {63'd0, req_ready}, 64'd1);
    chk("R8 quotient", {32'd0, seq_quot}, {32'd0, eq_quot});
    chk("R8 final remainder", {32'd0, resp_rem}, {32'd0, er});
    chk("R8 final q/m/t", {61'd0, resp_q, resp_m, resp_t}, {61'd0, eq, m0, et});
    @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk); #1;
    chk("R8 done is one cycle", {63'd0, seq_done}, 64'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R8 watchdog expired: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 ready in reset", {63'd0, req_ready}, 64'd1);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    chk("R1 resp_valid after reset", {63'd0, resp_valid}, 64'd0);
    chk("R1 seq_done after reset", {63'd0, seq_done}, 64'd0);
    chk("R1 ready after reset", {63'd0, req_ready}, 64'd1);

    // Table walked back to back (R2 R3 R4 R5 R6 R7)
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      req_valid   = 1'b1;
      req_op      = VEC[i][103:102];
      req_rem     = VEC[i][101:70];
      req_divisor = VEC[i][69:38];
      req_q       = VEC[i][37];
      req_m       = VEC[i][36];
      req_t       = VEC[i][35];
      @(posedge clk); #1;
      chk($sformatf("R7 resp_valid vec %0d", i), {63'd0, resp_valid}, 64'd1);
      chk($sformatf("R2 remainder vec %0d", i), {32'd0, resp_rem}, {32'd0, VEC[i][34:3]});
      chk($sformatf("R3 new q vec %0d", i), {63'd0, resp_q}, {63'd0, VEC[i][2]});
      chk($sformatf("R4 m/t vec %0d", i), {62'd0, resp_m, resp_t}, {62'd0, VEC[i][1:0]});
    end
    @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk); #1;
    chk("R7 no response when idle", {63'd0, resp_valid}, 64'd0);

    // Unsigned setup then run: 0 : dividend bits chained via T
    run_case(32'h00000000, 32'h00000007, 1'b0, 1'b0, 1'b1, 1'b0);
    // Signed-style flags, stray requests during run (R9)
    run_case(32'hFFFFFFF3, 32'hFFFFFFFB, 1'b1, 1'b1, 1'b0, 1'b1);
    run_case(32'h12345678, 32'h00010001, 1'b0, 1'b1, 1'b1, 1'b1);

    // Reset during a run (R1)
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd3; req_rem = 32'h0000FFFF; req_divisor = 32'h3;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1 ready after reset mid-run", {63'd0, req_ready}, 64'd1);
    repeat (40) @(posedge clk);
    #1;
    chk("R1 abandoned run gives no done", {63'd0, seq_done}, 64'd0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule